// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital controller of an 18-bit successive-approximation converter. The converter is built on a pair of binary-weighted capacitor arrays that feed a differential comparator. While it is idle the sequencer holds the converter in acquisition. The comparator nodes are grounded and every capacitor element follows the analog inputs. A falling edge on the active-low start input begins a conversion. The sequencer first releases the comparator-node grounds. On the following clock it moves both arrays onto the reference-ground terminal. It then runs a binary search one bit per trial, most significant bit first.

Each trial lifts one element to the reference. The sequencer waits a programmable number of settle clocks and then samples a one-bit comparator decision. A high decision means the node has not overshot, and the bit is kept. A low decision returns the element to reference ground. When the last trial has been decided, the result is written to the output register in straight binary or two's complement, as the coding input selects. BUSY falls on that same edge. The code is always that of the sample just taken.

Top module: `sar_conv_seq`

## Requirements
- R1: A synchronous active-high reset puts the block in acquisition: busy low, node_gnd_p and node_gnd_n high (closed), array_on_refgnd low (inputs), elem_to_ref all zero, code_out zero.
- R2: In acquisition, a clock edge that samples start_n low after it was sampled high starts a conversion, and busy is high from that edge on.
- R3: On the start edge both node grounds open while array_on_refgnd stays low. array_on_refgnd goes high one clock later. The grounds are never closed while the arrays sit on reference ground.
- R4: Trials run from bit 17 down to bit 0. The first begins two clocks after the start edge. Each lasts SETTLE_CLKS clocks, and during a trial elem_to_ref shows the bits already kept plus the bit on trial.
- R5: At the last clock of a trial, cmp_keep high keeps the bit under trial (1) and cmp_keep low clears it (0).
- R6: busy falls exactly 3 + 18*SETTLE_CLKS clocks after the start edge, and code_out changes on that same edge. The code is the result of the conversion just finished.
- R7: coding_twos is sampled on the edge where busy falls. Low gives straight binary (midscale 0x20000). High gives two's complement, which is the straight binary code with bit 17 inverted (midscale 0x00000).
- R8: An input above positive full scale gives 0x3FFFF in straight binary or 0x1FFFF in two's complement. An input below negative full scale gives 0x00000 or 0x20000.
- R9: Falling edges of start_n while busy is high are ignored. The conversion ends on time, and no second conversion follows it unless a new falling edge arrives in acquisition.
- R10: code_out changes only at the end of a conversion. Changes on coding_twos while idle leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Active-low convert start, synchronous to clk |
| cmp_keep | input | 1 | Comparator decision, high when the node has not overshot |
| coding_twos | input | 1 | Output coding: 0 straight binary, 1 two's complement |
| busy | output | 1 | High from conversion start until the code is written |
| node_gnd_p | output | 1 | Positive comparator-node ground switch, 1 closed |
| node_gnd_n | output | 1 | Negative comparator-node ground switch, 1 closed |
| array_on_refgnd | output | 1 | 0 elements on analog inputs, 1 elements on reference ground/reference |
| elem_to_ref | output | 18 | Per-element select of the reference, bit 17 the largest element |
| code_out | output | 18 | Conversion result register |

## Verification
Every result has a fixed delay from the start edge E0. After E0 busy is high and the grounds are open. After E0+1 the arrays sit on reference ground. The trial for bit 17-t is on show from E0+2+t*SETTLE_CLKS. Both busy and code_out settle at E0+3+18*SETTLE_CLKS. The bench counts falling clock edges from the cycle in which it drives start_n low and samples each output at the falling edge after the rising edge that updates it. Its comparator model answers from the trial vector the block puts out, so a bit kept in the wrong order or on the wrong clock changes that trial vector.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int DEF_CODE_W  = 18;
    localparam int DEF_SETTLE  = 2;

    typedef enum logic [2:0] {
        ST_ACQ   = 3'd0,
        ST_OPEN  = 3'd1,
        ST_MOVE  = 3'd2,
        ST_TRIAL = 3'd3,
        ST_DONE  = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       decide;
        logic       clear;
        logic       load;
    } seq_ctl_t;

    function automatic logic nodes_grounded(seq_state_e s);
        return (s == ST_ACQ);
    endfunction

    function automatic logic arrays_moved(seq_state_e s);
        return (s == ST_MOVE) || (s == ST_TRIAL) || (s == ST_DONE);
    endfunction

endpackage

// File: rtl/sar_start_edge.sv
module sar_start_edge (
    input  logic clk,
    input  logic rst,
    input  logic start_n,
    output logic start_fall
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= start_n;
    end

    assign start_fall = prev_q && !start_n;

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int CODE_W      = DEF_CODE_W,
    parameter int SETTLE_CLKS = DEF_SETTLE
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_fall,
    output seq_ctl_t                  ctl,
    output logic [$clog2(CODE_W)-1:0] bit_idx
);
    localparam int IW = $clog2(CODE_W);
    localparam int CW = $clog2(SETTLE_CLKS + 1);
    localparam logic [IW-1:0] TOP_IDX  = IW'(CODE_W - 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(SETTLE_CLKS - 1);

    seq_state_e      state_q;
    logic [CW-1:0]   cnt_q;
    logic [IW-1:0]   idx_q;
    logic            decide;

    assign decide = (state_q == ST_TRIAL) && (cnt_q == LAST_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ACQ;
            cnt_q   <= '0;
            idx_q   <= TOP_IDX;
        end else begin
            case (state_q)
                ST_ACQ: begin
                    if (start_fall) state_q <= ST_OPEN;
                end
                ST_OPEN: begin
                    state_q <= ST_MOVE;
                    idx_q   <= TOP_IDX;
                    cnt_q   <= '0;
                end
                ST_MOVE: begin
                    state_q <= ST_TRIAL;
                end
                ST_TRIAL: begin
                    if (decide) begin
                        cnt_q <= '0;
                        if (idx_q == '0) state_q <= ST_DONE;
                        else             idx_q   <= idx_q - 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DONE: begin
                    state_q <= ST_ACQ;
                end
                default: state_q <= ST_ACQ;
            endcase
        end
    end

    always_comb begin
        ctl.state  = state_q;
        ctl.decide = decide;
        ctl.clear  = (state_q == ST_ACQ) && start_fall;
        ctl.load   = (state_q == ST_DONE);
    end

    assign bit_idx = idx_q;

    // settle counter never passes its last value
    assert_settle_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TRIAL) |-> (cnt_q <= LAST_CNT));

    // deciding bit 0 ends the search on the next edge
    assert_last_trial_R6: assert property (@(posedge clk) disable iff (rst)
        (decide && idx_q == '0) |=> (state_q == ST_DONE));

    // a start edge seen in acquisition launches the sequence
    assert_start_launch_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACQ && start_fall) |=> (state_q == ST_OPEN));

endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg
    import sar_seq_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  seq_ctl_t                  ctl,
    input  logic [$clog2(CODE_W)-1:0] bit_idx,
    input  logic                      cmp_keep,
    output logic [CODE_W-1:0]         elem_ref,
    output logic [CODE_W-1:0]         result
);
    logic [CODE_W-1:0] sar_q;
    logic [CODE_W-1:0] trial_bit;

    assign trial_bit = {{(CODE_W-1){1'b0}}, 1'b1} << bit_idx;

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            sar_q <= '0;
        end else if (ctl.decide) begin
            sar_q[bit_idx] <= cmp_keep;
        end
    end

    always_comb begin
        case (ctl.state)
            ST_TRIAL: elem_ref = sar_q | trial_bit;
            ST_DONE:  elem_ref = sar_q;
            default:  elem_ref = '0;
        endcase
    end

    assign result = sar_q;

    // the decided bit equals the comparator answer of that trial
    assert_keep_rule_R5: assert property (@(posedge clk) disable iff (rst)
        ctl.decide |=> (sar_q[$past(bit_idx)] == $past(cmp_keep)));

    // outside the search no element is lifted
    assert_idle_elems_R1: assert property (@(posedge clk) disable iff (rst)
        (ctl.state == ST_ACQ) |-> (elem_ref == '0));

endmodule

// File: rtl/sar_code_out.sv
module sar_code_out
    import sar_seq_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_ctl_t          ctl,
    input  logic              coding_twos,
    input  logic [CODE_W-1:0] result,
    output logic [CODE_W-1:0] code
);
    localparam logic [CODE_W-1:0] SIGN_FLIP = {1'b1, {(CODE_W-1){1'b0}}};

    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
        end else if (ctl.load) begin
            code_q <= coding_twos ? (result ^ SIGN_FLIP) : result;
        end
    end

    assign code = code_q;

    // the register moves only at the end of a conversion
    assert_code_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(code_q) |-> $past(ctl.state) == ST_DONE);

    // reset clears the result
    assert_reset_code_R1: assert property (@(posedge clk)
        rst |=> (code_q == '0));

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_seq_pkg::*;
#(
    parameter int CODE_W      = DEF_CODE_W,
    parameter int SETTLE_CLKS = DEF_SETTLE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_n,
    input  logic              cmp_keep,
    input  logic              coding_twos,
    output logic              busy,
    output logic              node_gnd_p,
    output logic              node_gnd_n,
    output logic              array_on_refgnd,
    output logic [CODE_W-1:0] elem_to_ref,
    output logic [CODE_W-1:0] code_out
);
    localparam int IW = $clog2(CODE_W);

    logic              start_fall;
    seq_ctl_t          ctl;
    logic [IW-1:0]     bit_idx;
    logic [CODE_W-1:0] result;

    sar_start_edge u_edge (
        .clk        (clk),
        .rst        (rst),
        .start_n    (start_n),
        .start_fall (start_fall)
    );

    sar_seq_ctrl #(
        .CODE_W      (CODE_W),
        .SETTLE_CLKS (SETTLE_CLKS)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_fall (start_fall),
        .ctl        (ctl),
        .bit_idx    (bit_idx)
    );

    sar_approx_reg #(
        .CODE_W (CODE_W)
    ) u_sar (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .bit_idx  (bit_idx),
        .cmp_keep (cmp_keep),
        .elem_ref (elem_to_ref),
        .result   (result)
    );

    sar_code_out #(
        .CODE_W (CODE_W)
    ) u_fmt (
        .clk         (clk),
        .rst         (rst),
        .ctl         (ctl),
        .coding_twos (coding_twos),
        .result      (result),
        .code        (code_out)
    );

    assign busy            = (ctl.state != ST_ACQ);
    assign node_gnd_p      = nodes_grounded(ctl.state);
    assign node_gnd_n      = nodes_grounded(ctl.state);
    assign array_on_refgnd = arrays_moved(ctl.state);

    // arrays never reach reference ground with a node still grounded
    assert_gnd_vs_array_R3: assert property (@(posedge clk) disable iff (rst)
        array_on_refgnd |-> (!node_gnd_p && !node_gnd_n));

    // the grounds were already open one clock before the arrays moved
    assert_open_first_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(array_on_refgnd) |-> $past(!node_gnd_p && !node_gnd_n));

    // a start seen while idle raises busy
    assert_busy_rise_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_fall) |=> busy);

    // the result register never changes while a conversion runs
    assert_no_midconv_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && ctl.state != ST_OPEN) |-> $stable(code_out));

endmodule

// File: tb/sar_conv_seq_bench.sv
module sar_conv_seq_bench;

    localparam int W      = 18;
    localparam int SETTLE = 2;
    localparam int FULL   = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_n = 1'b1;
    logic         coding_twos = 1'b0;
    logic         cmp_keep;
    logic         busy, node_gnd_p, node_gnd_n, array_on_refgnd;
    logic [W-1:0] elem_to_ref, code_out;

    int vin = 0;
    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    // behavioural comparator: node not overshot while trial value <= input
    assign cmp_keep = (int'(elem_to_ref) <= vin);

    sar_conv_seq #(.CODE_W(W), .SETTLE_CLKS(SETTLE)) u_sar_conv_seq (
        .clk(clk), .rst(rst), .start_n(start_n), .cmp_keep(cmp_keep),
        .coding_twos(coding_twos), .busy(busy), .node_gnd_p(node_gnd_p),
        .node_gnd_n(node_gnd_n), .array_on_refgnd(array_on_refgnd),
        .elem_to_ref(elem_to_ref), .code_out(code_out)
    );

    function automatic int exp_binary(int v);
        if (v < 0)    return 0;
        if (v > FULL) return FULL;
        return v;
    endfunction

    function automatic int exp_code(int v, bit twos);
        return twos ? (exp_binary(v) ^ (1 << (W-1))) : exp_binary(v);
    endfunction

    task automatic chk(string req, int act, int expv);
        n_checks++;
        if (act != expv) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic convert(int v, bit twos, bit poke);
        int eb;
        vin = v;
        eb  = exp_binary(v);
        @(negedge clk);
        coding_twos = twos;
        start_n = 1'b0;
        @(negedge clk);                              // after E0
        chk("R2 busy", busy, 1);
        chk("R3 grounds open", {node_gnd_p, node_gnd_n}, 0);
        chk("R3 arrays still on inputs", array_on_refgnd, 0);
        start_n = 1'b1;
        @(negedge clk);                              // after E1
        chk("R3 arrays moved", array_on_refgnd, 1);
        chk("R4 no element before trials", elem_to_ref, 0);
        @(negedge clk);                              // after E2
        for (int t = 0; t < W; t++) begin
            int keep_mask;
            keep_mask = (t == 0) ? 0 : (eb & ~((1 << (W - t)) - 1));
            chk("R4/R5 trial vector", elem_to_ref, keep_mask | (1 << (W-1-t)));
            if (poke && t == 5) start_n = 1'b0;
            if (poke && t == 7) start_n = 1'b1;
            repeat (SETTLE) @(negedge clk);
        end
        chk("R6 busy before end", busy, 1);
        chk("R5 final search result", elem_to_ref, eb);
        @(negedge clk);                              // after E(3+18*SETTLE)
        chk("R6 busy low", busy, 0);
        chk("R7/R8 code", code_out, exp_code(v, twos));
        chk("R1 grounds closed again", {node_gnd_p, node_gnd_n}, 3);
        chk("R1 elements back on inputs", {array_on_refgnd, elem_to_ref}, 0);
    endtask

    initial begin
        int saved;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset switches", {node_gnd_p, node_gnd_n, array_on_refgnd}, 3'b110);
        chk("R1 reset code", code_out, 0);
        chk("R1 reset elements", elem_to_ref, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // directed corners
        convert(1 << (W-1), 1'b0, 1'b0);       // R7 midscale straight binary
        convert(1 << (W-1), 1'b1, 1'b0);       // R7 midscale two's complement
        convert(FULL, 1'b0, 1'b0);
        convert(FULL + 77, 1'b0, 1'b0);        // R8 overrange
        convert(FULL + 77, 1'b1, 1'b0);
        convert(-9, 1'b0, 1'b0);               // R8 underrange
        convert(-9, 1'b1, 1'b0);
        convert(0, 1'b1, 1'b0);
        convert(1, 1'b0, 1'b0);
        convert(FULL - 1, 1'b1, 1'b0);
        convert(12345, 1'b0, 1'b1);            // R9 start pulse during busy

        // R9: no extra conversion after an ignored start
        repeat (6) @(negedge clk);
        chk("R9 no restart", busy, 0);

        // R10: coding change while idle does not touch the code
        saved = int'(code_out);
        coding_twos = ~coding_twos;
        repeat (5) @(negedge clk);
        chk("R10 code held", code_out, saved);

        // constrained random
        for (int i = 0; i < 24; i++) begin
            int r;
            r = int'($urandom_range(FULL + 400, 0)) - 200;
            convert(r, 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
            repeat (int'($urandom_range(3, 0))) @(negedge clk);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule